// File: doc/BRIEF.md
# Interlocked RTS/CTS Character Link

This block is a matched pair of handshake engines that move one character at a time across a serial wire. The sending engine waits for a local launch request, raises a request line, and holds off until the far side grants the transfer. It then shifts the character out, drops its request, and waits for the grant to be withdrawn before it accepts new work. The receiving engine notices the request and waits for its own local permission before it grants. It then captures the character, waits for the request to fall, and withdraws the grant, presenting the byte at that moment.

Both engines step through a fixed ring of four states for every character. Neither can begin a new character until both have come back to rest, so the pair never overruns. The request and grant lines each cross into the other engine through a two-flop synchronizer. This lets the two halves be placed apart or clocked with skew. The serial frame is one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts `bit_cycles` clock cycles, where `bit_cycles` must be at least 4.

Top module: `rts_cts_link`

## Requirements
- R1: After reset, `rts`, `cts`, `tx_busy`, `tx_done` and `rx_valid` are 0 and `ser_line` is 1.
- R2: A `go` pulse while the sender is at rest raises `rts` and `tx_busy` on the next clock edge.
- R3: While the sender waits for the grant, `ser_line` stays 1.
- R4: The frame on `ser_line` is a 0 start bit, then `tx_data` bit 0 through bit 7, then a 1 stop bit. Each bit lasts `bit_cycles` cycles.
- R5: After the stop bit the sender lowers `rts`. It pulses `tx_done` for one cycle, with `tx_busy` low, only after it has seen `cts` fall.
- R6: The receiver keeps `cts` low until it has seen `rts` high and `rx_ok` is 1. Without `rts`, `rx_ok` alone never raises `cts`.
- R7: The receiver keeps `cts` high until it sees `rts` low. In the cycle that `cts` falls, it pulses `rx_valid` for exactly one cycle, with `rx_data` equal to the captured byte.
- R8: A `go` pulse while `tx_busy` is 1 is ignored. No second request or frame follows it.
- R9: Each engine advances only to the next state of its four-state ring (rest, request/await, transfer, release). It is back at rest, with `tx_busy` 0, when a character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both engines |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Launch request for one character |
| tx_data | input | DATA_W | Character to send, sampled when the grant is seen |
| bit_cycles | input | CNT_W | Clock cycles per serial bit (at least 4) |
| rx_ok | input | 1 | Receiver-side permission to grant |
| rts | output | 1 | Request line driven by the sender |
| cts | output | 1 | Grant line driven by the receiver |
| ser_line | output | 1 | Serial data wire, 1 when idle |
| tx_busy | output | 1 | Sender is not at rest |
| tx_done | output | 1 | One-cycle pulse when the sender returns to rest |
| rx_valid | output | 1 | One-cycle pulse carrying a received byte |
| rx_data | output | DATA_W | Byte captured by the receiver |

## Verification
A sender stuck outside its rest state shows within one cycle as `tx_busy` or `rts` held high after `tx_done`. A sender that skips the wait for the grant shows as a start bit on `ser_line` while `cts` is still 0. A receiver that samples in the wrong place, or shifts in the wrong direction, shows as a mismatched `rx_data` at the `rx_valid` pulse, about ten bit periods after the start bit. A broken interlock shows as `cts` rising before `rx_ok`, or as `rx_valid` firing while `rts` is still high. Both appear at the next edge after the offending event.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    TX_REST  = 2'd0,
    TX_ASK   = 2'd1,
    TX_SHIFT = 2'd2,
    TX_DROP  = 2'd3
  } tx_st_t;

  typedef enum logic [1:0] {
    RX_REST  = 2'd0,
    RX_HOLD  = 2'd1,
    RX_TAKE  = 2'd2,
    RX_WIND  = 2'd3
  } rx_st_t;

  // cycles from first low sample of the start bit to the middle of data bit 0
  function automatic logic [31:0] first_sample_gap(input logic [31:0] len);
    return len + (len >> 1) - 32'd1;
  endfunction

  // reload value of a per-bit down counter
  function automatic logic [31:0] bit_reload(input logic [31:0] len);
    return len - 32'd1;
  endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/hs_sender.sv
module hs_sender #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic              grant_s,
  output logic              req,
  output logic              line,
  output logic              busy,
  output logic              done
);
  import hs_pkg::*;

  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  tx_st_t             st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [31:0]        reload_w;

  // named internal events
  logic launch_ev, bit_end_ev, last_bit_ev;

  assign reload_w    = bit_reload(32'(bit_cycles));
  assign launch_ev   = (st_q == TX_REST) && go;
  assign bit_end_ev  = (st_q == TX_SHIFT) && (cnt_q == '0);
  assign last_bit_ev = bit_end_ev && (idx_q == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_REST;
      sh_q  <= '1;
      cnt_q <= '0;
      idx_q <= '0;
      req   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        TX_REST: if (launch_ev) begin
          st_q <= TX_ASK;
          req  <= 1'b1;
        end
        TX_ASK: if (grant_s) begin
          st_q  <= TX_SHIFT;
          sh_q  <= {1'b1, data, 1'b0};
          cnt_q <= reload_w[CNT_W-1:0];
          idx_q <= '0;
        end
        TX_SHIFT: begin
          if (bit_end_ev) begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= reload_w[CNT_W-1:0];
            idx_q <= idx_q + 1'b1;
            if (last_bit_ev) begin
              st_q <= TX_DROP;
              req  <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        TX_DROP: if (!grant_s) begin
          st_q <= TX_REST;
          done <= 1'b1;
        end
        default: st_q <= TX_REST;
      endcase
    end
  end

  assign line = sh_q[0];
  assign busy = (st_q != TX_REST);

  assert_req_on_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ev |=> (req && busy));

  assert_quiet_while_asking_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_ASK) |-> line);

  assert_done_after_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req && !busy && !grant_s));

  assert_go_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TX_SHIFT) && go) |=> (st_q != TX_ASK));

  assert_ring_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q == $past(st_q)) || (st_q == tx_st_t'($past(st_q) + 2'd1))));

endmodule

// File: rtl/hs_receiver.sv
module hs_receiver #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              ok,
  input  logic              line,
  input  logic [CNT_W-1:0]  bit_cycles,
  output logic              grant,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  import hs_pkg::*;

  localparam int XW    = CNT_W + 1;
  localparam int IDX_W = $clog2(DATA_W + 1);

  rx_st_t            st_q;
  logic              hunt_q;
  logic [XW-1:0]     cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic [31:0]       gap_w, reload_w;

  // named internal events
  logic start_seen_ev, sample_ev, stop_ev, release_ev;

  assign gap_w         = first_sample_gap(32'(bit_cycles));
  assign reload_w      = bit_reload(32'(bit_cycles));
  assign start_seen_ev = (st_q == RX_TAKE) && hunt_q && !line;
  assign sample_ev     = (st_q == RX_TAKE) && !hunt_q && (cnt_q == '0);
  assign stop_ev       = sample_ev && (idx_q == IDX_W'(DATA_W));
  assign release_ev    = (st_q == RX_WIND) && !req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_REST;
      hunt_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      grant  <= 1'b0;
      valid  <= 1'b0;
      data   <= '0;
    end else begin
      valid <= 1'b0;
      unique case (st_q)
        RX_REST: if (req_s) st_q <= RX_HOLD;
        RX_HOLD: if (ok) begin
          st_q   <= RX_TAKE;
          grant  <= 1'b1;
          hunt_q <= 1'b1;
          idx_q  <= '0;
        end
        RX_TAKE: begin
          if (start_seen_ev) begin
            hunt_q <= 1'b0;
            cnt_q  <= gap_w[XW-1:0];
          end else if (stop_ev) begin
            st_q <= RX_WIND;
          end else if (sample_ev) begin
            sh_q  <= {line, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + 1'b1;
            cnt_q <= reload_w[XW-1:0];
          end else if (!hunt_q) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RX_WIND: if (release_ev) begin
          st_q  <= RX_REST;
          grant <= 1'b0;
          valid <= 1'b1;
          data  <= sh_q;
        end
        default: st_q <= RX_REST;
      endcase
    end
  end

  assert_grant_waits_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != RX_TAKE) && (st_q != RX_WIND) && !ok) |=> !grant);

  assert_valid_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (!grant && $past(grant) && !$past(req_s)));

  assert_ring_order_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q == $past(st_q)) || (st_q == rx_st_t'($past(st_q) + 2'd1))));

endmodule

// File: rtl/rts_cts_link.sv
module rts_cts_link #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic              rx_ok,
  output logic              rts,
  output logic              cts,
  output logic              ser_line,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  logic rts_at_rx, cts_at_tx;

  hs_sync2 u_sync_req (.clk(clk), .rst_n(rst_n), .d(rts), .q(rts_at_rx));
  hs_sync2 u_sync_gnt (.clk(clk), .rst_n(rst_n), .d(cts), .q(cts_at_tx));

  hs_sender #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go), .data(tx_data), .bit_cycles(bit_cycles),
    .grant_s(cts_at_tx), .req(rts), .line(ser_line), .busy(tx_busy), .done(tx_done)
  );

  hs_receiver #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .req_s(rts_at_rx), .ok(rx_ok), .line(ser_line),
    .bit_cycles(bit_cycles), .grant(cts), .valid(rx_valid), .data(rx_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!rst_n ? (!rts && !cts && ser_line && !rx_valid) : 1'b1));

  assert_no_frame_without_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts && !rts) |-> ser_line);

endmodule

// File: tb/rts_cts_link_tb.sv
module rts_cts_link_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic [15:0] bit_cycles = 16'd4;
  logic        rx_ok = 1'b0;
  logic        rts, cts, ser_line, tx_busy, tx_done, rx_valid;
  logic [7:0]  rx_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;  // 50 MHz

  rts_cts_link u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_data(tx_data), .bit_cycles(bit_cycles),
    .rx_ok(rx_ok), .rts(rts), .cts(cts), .ser_line(ser_line), .tx_busy(tx_busy),
    .tx_done(tx_done), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  // byte, bit length, cycles of rx_ok delay after rts rises
  localparam logic [23:0] VEC [5] = '{
    {8'hA5, 8'd4, 8'd0},
    {8'h00, 8'd5, 8'd3},
    {8'hFF, 8'd8, 8'd7},
    {8'h3C, 8'd6, 8'd1},
    {8'h81, 8'd9, 8'd12}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic run_one(input logic [7:0] b, input int len, input int okd);
    int t;
    @(negedge clk);
    go = 1'b1; tx_data = b; bit_cycles = 16'(len);
    @(negedge clk);
    go = 1'b0;
    chk(rts && tx_busy, "R2 rts/busy after go", {rts, tx_busy}, 2'b11);
    for (int i = 0; i < okd; i++) begin
      go = (i == 0);  // R8 stray launch while busy
      chk(!cts, "R6 cts held low before rx_ok", cts, 0);
      chk(ser_line, "R3 line idle before grant", ser_line, 1);
      @(negedge clk);
    end
    go = 1'b0;
    rx_ok = 1'b1;
    t = 0;
    while (ser_line && t < 500) begin @(negedge clk); t++; end
    chk(!ser_line, "R4 start bit appears", ser_line, 0);
    chk(cts, "R6 cts high during frame", cts, 1);
    repeat (len / 2) @(negedge clk);
    chk(!ser_line, "R4 start bit mid", ser_line, 0);
    for (int k = 0; k < 8; k++) begin
      repeat (len) @(negedge clk);
      chk(ser_line == b[k], "R4 data bit", ser_line, b[k]);
    end
    repeat (len) @(negedge clk);
    chk(ser_line, "R4 stop bit", ser_line, 1);
    t = 0;
    while (!rx_valid && t < 200) begin @(negedge clk); t++; end
    chk(rx_valid && rx_data == b, "R7 rx_data at rx_valid", rx_data, b);
    chk(!cts && !rts, "R7 R5 cts/rts low at rx_valid", {rts, cts}, 0);
    rx_ok = 1'b0;
    @(negedge clk);
    chk(!rx_valid, "R7 rx_valid single cycle", rx_valid, 0);
    t = 0;
    while (!tx_done && t < 200) begin @(negedge clk); t++; end
    chk(tx_done && !tx_busy, "R5 tx_done with busy low", {tx_done, tx_busy}, 2'b10);
    @(negedge clk);
    chk(!tx_done, "R5 tx_done single cycle", tx_done, 0);
    repeat (30) @(negedge clk);
    chk(!rts && ser_line && !tx_busy, "R8 R9 no second request, back at rest",
        {rts, ser_line, tx_busy}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rts && !cts && ser_line && !tx_busy && !tx_done && !rx_valid, "R1 reset state",
        {rts, cts, ser_line, tx_busy, tx_done, rx_valid}, 6'b001000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rts && !cts && ser_line, "R1 after reset release", {rts, cts, ser_line}, 3'b001);

    // table-driven transfers
    for (int v = 0; v < 5; v++)
      run_one(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

    // directed: rx_ok alone must not grant
    rx_ok = 1'b1;
    repeat (12) @(negedge clk);
    chk(!cts, "R6 rx_ok without rts leaves cts low", cts, 0);
    rx_ok = 1'b0;

    // directed: back-to-back characters, second launched right after done
    run_one(8'h5A, 4, 2);
    run_one(8'hC3, 4, 0);

    summary();
    $finish;
  end
endmodule